// File: doc/BRIEF.md
# SPI Packet-Buffer Command Engine

This block is an SPI master sequencer that executes one transfer at a time out of a shared 512-byte packet buffer. Software loads the buffer through a byte-write port. The first two bytes hold a 16-bit command word that describes the operation, the data-line width and the byte count. Software then writes a command register with a start code and a slave-select index. The engine reads the header, shifts the payload out from byte offset 2, and writes the bytes it receives back into the same buffer from offset 0. It drives one of eight chip-select lines at a programmable active level for the whole length of the run.

Serial clock generation happens outside the block. Each `sck_en` strobe moves the shifter by one step: one bit on a single line, or two bits on two lines. On completion a sticky done bit is set in a small write-1-to-clear status register. The interrupt output is the OR of the status bits that are enabled by a mask.

Top module: `spi_cmd_engine`

## Requirements
- R1: While idle, a byte write (`buf_wr_en`, `buf_addr`, `buf_wdata`) stores into the buffer, and `buf_rdata` always returns the byte at `buf_raddr`. Software writes made while `busy` is high are ignored.
- R2: The header is byte 0 (command bits 15:8) followed by byte 1 (bits 7:0). Bits 15:13 give the operation: 0 sleep, 1 read-and-write, 2 write only, 3 read only, 4 set-interrupt. Bit 11 selects dual-line data. Bits 10:0 give the byte count. A run lasts exactly that many bytes.
- R3: Transmit bytes come from buffer offsets 2, 3 and onward, most significant bit first. In single-line mode, `sd_out[0]` carries the current bit and `sd_in[1]` is sampled on each strobe. Read-and-write and read-only runs store received byte k at offset k.
- R4: In dual-line mode each strobe moves two bits, and the higher-order bit is on line 1. A dual write drives both lines (`sd_oe`=11). A dual read releases both lines (`sd_oe`=00) and samples both.
- R5: Write-only and sleep runs leave the buffer unchanged. Read-only and sleep runs hold `sd_out[0]` at the idle level. When no run is active, `sd_oe`=01 and `sd_out[0]` follows control bit 18 (idle level).
- R6: A header is rejected, and bit 4 of the status register is set with no run and no chip-select, in any of these cases:
  - the count exceeds 510 for write or read-and-write;
  - the count exceeds 512 for read or sleep;
  - the operation code is 5 to 7;
  - dual-line is requested with read-and-write.
- R7: A legal header with count 0, or the set-interrupt operation, sets status bit 0 on the edge that takes the start command, without asserting any chip-select.
- R8: Control bits 7:0 give each chip-select its active level. The line picked by command bits 14:12 is at its active level only while a run is active. Every other line, and every line while idle, sits at the inverse of its polarity bit.
- R9: The command register field is bits 3:0. Code 0 does nothing. Code 1 starts a run when idle and is ignored while busy. Codes 3 (halt) and 4 (flush) end a run at once without setting done. Code 2 (start on external trigger) and codes 5 to 15 set status bit 4.
- R10: Status bit 0 is set when the last byte finishes. A status write clears the bits written as 1. `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: After reset, status, mask, polarity and idle level are all 0, `busy` is low, `cs_out` is all ones and `sd_oe`=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_wr_en | input | 1 | Software byte write strobe |
| buf_addr | input | 9 | Software write address |
| buf_wdata | input | 8 | Software write data |
| buf_raddr | input | 9 | Read-back address |
| buf_rdata | output | 8 | Read-back data |
| ctrl_wr | input | 1 | Control register write |
| ctrl_wdata | input | 32 | Control value: bits 7:0 polarity, bit 18 idle level |
| cmd_wr | input | 1 | Command register write |
| cmd_wdata | input | 16 | Command: bits 3:0 code, 11:8 profile (unused), 14:12 slave select |
| sts_wr | input | 1 | Status write-1-to-clear strobe |
| sts_wdata | input | 5 | Bits to clear |
| mask_wr | input | 1 | Mask register write |
| mask_wdata | input | 5 | Interrupt mask value |
| sck_en | input | 1 | Shift step strobe |
| sd_in | input | 2 | Serial data inputs, lines 1 and 0 |
| sd_out | output | 2 | Serial data outputs, lines 1 and 0 |
| sd_oe | output | 2 | Output enables for lines 1 and 0 |
| cs_out | output | 8 | Chip-select lines |
| busy | output | 1 | A run is active |
| status | output | 5 | Sticky status: bit 0 done, bit 4 invalid control |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong byte index or step counter shows up on the next strobe. It appears as a wrong bit on `sd_out`, or it moves the final strobe and with it the fall of `busy` and the rise of the done bit. A bad receive path first becomes visible once the run ends, when the buffer is read back and a byte at offset k does not hold the k-th byte the slave model sent. Mistakes in header decoding appear one edge after the start command: the chip-select level, `busy` and status bit 4 are wrong on the following cycle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BUF_BYTES = 512;
  localparam int HDR_BYTES = 2;
  localparam int NUM_CS    = 8;
  localparam int NUM_STS   = 5;

  // header operation codes (bits 15:13 of the command word)
  localparam logic [2:0] OP_SLEEP = 3'd0;
  localparam logic [2:0] OP_XFER  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd4;

  // command register codes (bits 3:0)
  localparam logic [3:0] CMD_NOOP  = 4'd0;
  localparam logic [3:0] CMD_GO    = 4'd1;
  localparam logic [3:0] CMD_TRIG  = 4'd2;
  localparam logic [3:0] CMD_HALT  = 4'd3;
  localparam logic [3:0] CMD_FLUSH = 4'd4;

  localparam int STS_DONE  = 0;
  localparam int STS_INVAL = 4;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;

  function automatic logic op_sends(input logic [2:0] op);
    return (op == OP_XFER) || (op == OP_WRITE);
  endfunction

  function automatic logic op_stores(input logic [2:0] op);
    return (op == OP_XFER) || (op == OP_READ);
  endfunction

  // largest byte count an operation may request
  function automatic int byte_cap(input logic [2:0] op, input int depth, input int hdr);
    return op_sends(op) ? depth - hdr : depth;
  endfunction

  function automatic logic header_ok(input logic [2:0] op, input logic dual,
                                     input int cnt, input int depth, input int hdr);
    if (op > OP_IRQ) return 1'b0;
    if (dual && op == OP_XFER) return 1'b0;
    return cnt <= byte_cap(op, depth, hdr);
  endfunction

  // last step index inside one byte
  function automatic logic [2:0] last_step(input logic dual);
    return dual ? 3'd3 : 3'd7;
  endfunction

  function automatic logic [NUM_CS-1:0] cs_levels(input logic [NUM_CS-1:0] pol,
                                                  input int sel, input logic on);
    logic [NUM_CS-1:0] lv;
    for (int i = 0; i < NUM_CS; i++)
      lv[i] = (on && sel == i) ? pol[i] : ~pol[i];
    return lv;
  endfunction
endpackage

// File: rtl/spi_pkt_buffer.sv
module spi_pkt_buffer #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data,
  output logic [15:0]   hdr_word
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data  = mem[ra_addr];
  assign rb_data  = mem[rb_addr];
  assign hdr_word = {mem[0], mem[1]};

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)); // R1
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       dual,
  input  logic       step,
  input  logic [1:0] sd_in,
  output logic [1:0] lines,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  logic [7:0] sh_q, rx_q;
  logic [2:0] cnt_q;

  assign lines     = sh_q[7:6];
  assign rx_byte   = dual ? {rx_q[5:0], sd_in[1], sd_in[0]} : {rx_q[6:0], sd_in[1]};
  assign byte_done = step && (cnt_q == last_step(dual));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (step) begin
        rx_q  <= rx_byte;
        cnt_q <= byte_done ? 3'd0 : cnt_q + 3'd1;
        sh_q  <= dual ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
      end
      if (load) begin
        sh_q  <= load_byte;
        cnt_q <= '0;
      end
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !byte_done || dual); // R3
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [NB-1:0] clr_vec,
  input  logic          mask_wr,
  input  logic [NB-1:0] mask_vec,
  output logic [NB-1:0] status,
  output logic          irq
);
  logic [NB-1:0] sts_q, mask_q, clr_eff;

  assign clr_eff = clr_wr ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_eff) | set_vec;
      if (mask_wr) mask_q <= mask_vec;
    end
  end

  assign status = sts_q;
  assign irq    = |(sts_q & mask_q);

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_vec[0] && !set_vec[0]) |=> !status[0]); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(clr_wr && clr_vec[0])) |=> status[0]); // R10
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = spi_cmd_pkg::BUF_BYTES,
  parameter int NCS   = spi_cmd_pkg::NUM_CS,
  parameter int NSTS  = spi_cmd_pkg::NUM_STS,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = 11,
  localparam int SW = $clog2(NCS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_wr_en,
  input  logic [AW-1:0]   buf_addr,
  input  logic [7:0]      buf_wdata,
  input  logic [AW-1:0]   buf_raddr,
  output logic [7:0]      buf_rdata,
  input  logic            ctrl_wr,
  input  logic [31:0]     ctrl_wdata,
  input  logic            cmd_wr,
  input  logic [15:0]     cmd_wdata,
  input  logic            sts_wr,
  input  logic [NSTS-1:0] sts_wdata,
  input  logic            mask_wr,
  input  logic [NSTS-1:0] mask_wdata,
  input  logic            sck_en,
  input  logic [1:0]      sd_in,
  output logic [1:0]      sd_out,
  output logic [1:0]      sd_oe,
  output logic [NCS-1:0]  cs_out,
  output logic            busy,
  output logic [NSTS-1:0] status,
  output logic            irq
);
  eng_state_e      state_q;
  logic [2:0]      op_q;
  logic            dual_q;
  logic [CW-1:0]   cnt_q, idx_q;
  logic [SW-1:0]   sel_q;
  logic [NCS-1:0]  pol_q;
  logic            idle_q;

  logic [15:0]     hdr;
  logic [2:0]      h_op;
  logic            h_dual;
  logic [CW-1:0]   h_cnt;
  logic [3:0]      code;
  logic            running, go, hdr_good, quick, launch, abort, bad_cmd;
  logic            step, byte_done, last_byte, load, done_evt, inval_evt, rx_we;
  logic [2:0]      op_eff;
  logic            dual_eff;
  logic [CW-1:0]   nxt_idx, tx_pos;
  logic [7:0]      tx_byte, load_byte, rx_byte;
  logic [1:0]      sh_lines;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [7:0]      mem_wdata;
  logic [NSTS-1:0] set_vec;
  logic            unused_bits;

  assign unused_bits = ^{cmd_wdata[15], cmd_wdata[11:4], ctrl_wdata[31:19],
                         ctrl_wdata[17:8], hdr[12]};

  assign running = (state_q == ST_SHIFT);
  assign h_op    = hdr[15:13];
  assign h_dual  = hdr[11];
  assign h_cnt   = hdr[CW-1:0];
  assign code    = cmd_wdata[3:0];

  assign go       = cmd_wr && code == CMD_GO && !running;
  assign hdr_good = header_ok(h_op, h_dual, int'(h_cnt), DEPTH, HDR_BYTES);
  assign quick    = go && hdr_good && (h_op == OP_IRQ || h_cnt == '0);
  assign launch   = go && hdr_good && !quick;
  assign abort    = cmd_wr && (code == CMD_HALT || code == CMD_FLUSH) && running;
  assign bad_cmd  = cmd_wr && (code == CMD_TRIG || code > CMD_FLUSH);

  assign step      = running && sck_en;
  assign last_byte = byte_done && (idx_q + CW'(1) == cnt_q);
  assign done_evt  = (quick || last_byte) && !abort;
  assign inval_evt = bad_cmd || (go && !hdr_good);
  assign load      = launch || (byte_done && !last_byte && !abort);

  assign op_eff   = running ? op_q : h_op;
  assign dual_eff = running ? dual_q : h_dual;
  assign nxt_idx  = running ? idx_q + CW'(1) : '0;
  assign tx_pos   = nxt_idx + CW'(HDR_BYTES);
  assign load_byte = op_sends(op_eff) ? tx_byte : {8{idle_q}};

  assign rx_we     = byte_done && op_stores(op_q);
  assign mem_we    = running ? rx_we : buf_wr_en;
  assign mem_waddr = running ? idx_q[AW-1:0] : buf_addr;
  assign mem_wdata = running ? rx_byte : buf_wdata;

  spi_pkt_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .ra_addr  (buf_raddr),
    .ra_data  (buf_rdata),
    .rb_addr  (tx_pos[AW-1:0]),
    .rb_data  (tx_byte),
    .hdr_word (hdr)
  );

  spi_byte_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (load_byte),
    .dual      (dual_eff),
    .step      (step),
    .sd_in     (sd_in),
    .lines     (sh_lines),
    .rx_byte   (rx_byte),
    .byte_done (byte_done)
  );

  always_comb begin
    set_vec = '0;
    set_vec[STS_DONE]  = done_evt;
    set_vec[STS_INVAL] = inval_evt;
  end

  spi_irq_status #(.NB(NSTS)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (sts_wr),
    .clr_vec  (sts_wdata),
    .mask_wr  (mask_wr),
    .mask_vec (mask_wdata),
    .status   (status),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      idle_q <= 1'b0;
    end else if (ctrl_wr) begin
      pol_q  <= ctrl_wdata[NCS-1:0];
      idle_q <= ctrl_wdata[18];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SLEEP;
      dual_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sel_q   <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else if (launch) begin
      state_q <= ST_SHIFT;
      op_q    <= h_op;
      dual_q  <= h_dual;
      cnt_q   <= h_cnt;
      idx_q   <= '0;
      sel_q   <= cmd_wdata[12 +: SW];
    end else if (byte_done) begin
      idx_q <= idx_q + CW'(1);
      if (last_byte) state_q <= ST_IDLE;
    end
  end

  always_comb begin
    if (!running) begin
      sd_oe  = 2'b01;
      sd_out = {1'b0, idle_q};
    end else if (dual_q && op_q == OP_WRITE) begin
      sd_oe  = 2'b11;
      sd_out = sh_lines;
    end else if (dual_q && op_q == OP_READ) begin
      sd_oe  = 2'b00;
      sd_out = 2'b00;
    end else begin
      sd_oe  = 2'b01;
      sd_out = {1'b0, sh_lines[1]};
    end
  end

  assign cs_out = cs_levels(pol_q, int'(sel_q), running);
  assign busy   = running;

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_out == ~pol_q); // R8
  AST_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_oe == 2'b01 && sd_out[0] == idle_q)); // R5
  AST_RX_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && busy |-> byte_done); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx_q < cnt_q); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy); // R7
  AST_HALT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !set_vec[STS_DONE]); // R9
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_wr_en = 1'b0;
  logic [8:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic [8:0]  buf_raddr = '0;
  logic [7:0]  buf_rdata;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        sts_wr = 1'b0;
  logic [4:0]  sts_wdata = '0;
  logic        mask_wr = 1'b0;
  logic [4:0]  mask_wdata = '0;
  logic        sck_en = 1'b0;
  logic [1:0]  sd_in = '0;
  logic [1:0]  sd_out, sd_oe;
  logic [7:0]  cs_out;
  logic        busy, irq;
  logic [4:0]  status;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  spi_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .sck_en(sck_en), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .cs_out(cs_out),
    .busy(busy), .status(status), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        dual;
    logic [10:0] cnt;
    logic [2:0]  sel;
    logic [7:0]  pol;
    logic        idle;
    logic [4:0]  seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 11'd4,   3'd2, 8'h00, 1'b0, 5'd1},
    '{3'd2, 1'b0, 11'd3,   3'd5, 8'h20, 1'b1, 5'd2},
    '{3'd3, 1'b0, 11'd5,   3'd0, 8'hFF, 1'b1, 5'd3},
    '{3'd2, 1'b1, 11'd4,   3'd7, 8'h0F, 1'b0, 5'd4},
    '{3'd3, 1'b1, 11'd6,   3'd1, 8'h02, 1'b0, 5'd5},
    '{3'd0, 1'b0, 11'd2,   3'd3, 8'h00, 1'b1, 5'd6},
    '{3'd1, 1'b0, 11'd510, 3'd4, 8'h00, 1'b0, 5'd7},
    '{3'd3, 1'b0, 11'd512, 3'd6, 8'h00, 1'b0, 5'd8}
  };

  function automatic logic [7:0] tx_pat(input int seed, input int i);
    return 8'((i * 7 + seed * 13 + 1) & 255);
  endfunction
  function automatic logic [7:0] rx_pat(input int seed, input int i);
    return 8'((i * 29 + seed * 5 + 90) & 255);
  endfunction
  function automatic logic [7:0] exp_cs(input logic [7:0] pol, input int sel, input bit on);
    logic [7:0] r;
    r = ~pol;
    if (on) r[sel] = pol[sel];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [7:0] d);
    buf_wr_en = 1; buf_addr = 9'(a); buf_wdata = d;
    @(negedge clk);
    buf_wr_en = 0;
  endtask
  task automatic rd(input int a, output logic [7:0] d);
    buf_raddr = 9'(a);
    #0.1;
    d = buf_rdata;
  endtask
  task automatic ctrl(input logic [7:0] pol, input logic idle);
    ctrl_wr = 1; ctrl_wdata = {13'd0, idle, 10'd0, pol};
    @(negedge clk);
    ctrl_wr = 0;
  endtask
  task automatic cmd(input logic [3:0] c, input logic [2:0] sel);
    cmd_wr = 1; cmd_wdata = {1'b0, sel, 4'h3, 4'h0, c};
    @(negedge clk);
    cmd_wr = 0;
  endtask
  task automatic clr_sts(input logic [4:0] v);
    sts_wr = 1; sts_wdata = v;
    @(negedge clk);
    sts_wr = 0;
  endtask
  task automatic hdr(input logic [2:0] op, input logic dual, input logic [10:0] cnt);
    logic [15:0] w;
    w = {op, 1'b0, dual, cnt};
    bw(0, w[15:8]);
    bw(1, w[7:0]);
  endtask
  task automatic strobe(input logic [1:0] din);
    sd_in = din; sck_en = 1;
    @(negedge clk);
    sck_en = 0;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int nb, steps, bad_tx, bad_cs, bad_rx, sd;
    logic [7:0] d;
    nb = int'(v.cnt);
    sd = int'(v.seed);
    steps = v.dual ? 4 : 8;
    ctrl(v.pol, v.idle);
    hdr(v.op, v.dual, v.cnt);
    if (v.op == 3'd1 || v.op == 3'd2)
      for (int i = 0; i < nb; i++) bw(i + 2, tx_pat(sd, i));
    cmd(4'd1, v.sel);
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    chk(cs_out === exp_cs(v.pol, v.sel, 1), "R8 cs active", cs_out, exp_cs(v.pol, v.sel, 1));
    bad_tx = 0; bad_cs = 0;
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < steps; s++) begin
        logic [7:0] tb_tx, tb_rx;
        tb_tx = tx_pat(sd, b);
        tb_rx = rx_pat(sd, b);
        if (cs_out !== exp_cs(v.pol, v.sel, 1) || busy !== 1'b1) bad_cs++;
        if (v.dual) begin
          if (v.op == 3'd2) begin
            if (sd_oe !== 2'b11 || sd_out !== {tb_tx[7 - 2*s], tb_tx[6 - 2*s]}) bad_tx++;
          end else if (sd_oe !== 2'b00) bad_tx++;
          strobe({tb_rx[7 - 2*s], tb_rx[6 - 2*s]});
        end else begin
          if (v.op == 3'd1 || v.op == 3'd2) begin
            if (sd_out[0] !== tb_tx[7 - s]) bad_tx++;
          end else if (sd_out[0] !== v.idle) bad_tx++;
          if (sd_oe !== 2'b01) bad_tx++;
          strobe({tb_rx[7 - s], 1'b0});
        end
      end
    end
    chk(bad_tx == 0, v.dual ? "R4 dual line bits" : "R3 line0 bits", bad_tx, 0);
    chk(bad_cs == 0, "R8 cs held over run", bad_cs, 0);
    chk(busy === 1'b0 && status[0] === 1'b1, "R10 done after last byte", {busy, status[0]}, 2'b01);
    chk(cs_out === ~v.pol, "R8 cs released", cs_out, ~v.pol);
    bad_rx = 0;
    if (v.op == 3'd1 || v.op == 3'd3) begin
      for (int b = 0; b < nb; b++) begin
        rd(b, d);
        if (d !== rx_pat(sd, b)) bad_rx++;
      end
      chk(bad_rx == 0, "R3 rx stored from offset 0", bad_rx, 0);
    end else begin
      for (int b = 0; b < nb; b++) begin
        rd(b + 2, d);
        if (v.op == 3'd2 && d !== tx_pat(sd, b)) bad_rx++;
      end
      rd(0, d);
      if (d !== {v.op, 1'b0, v.dual, v.cnt[10:8]}) bad_rx++;
      chk(bad_rx == 0, "R5 buffer unchanged", bad_rx, 0);
    end
    clr_sts(5'h1F);
    chk(status === 5'd0, "R10 w1c clear", status, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(status === 5'd0 && irq === 1'b0 && busy === 1'b0, "R11 reset status", {status, irq, busy}, 0);
    chk(cs_out === 8'hFF, "R11 reset cs", cs_out, 8'hFF);
    chk(sd_oe === 2'b01 && sd_out[0] === 1'b0, "R11 reset lines", {sd_oe, sd_out}, 4'b0100);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    ctrl(8'h00, 1'b1);
    chk(sd_out[0] === 1'b1 && sd_oe === 2'b01, "R5 idle level follows control", sd_out[0], 1);

    // R7 zero count and set-interrupt op
    hdr(3'd2, 1'b0, 11'd0);
    cmd(4'd1, 3'd1);
    chk(busy === 1'b0 && status === 5'd1 && cs_out === 8'hFF, "R7 zero count done", {busy, status}, 1);
    clr_sts(5'h1F);
    hdr(3'd4, 1'b0, 11'd5);
    cmd(4'd1, 3'd1);
    chk(busy === 1'b0 && status === 5'd1 && cs_out === 8'hFF, "R7 set-interrupt op", {busy, status}, 1);

    // R10 irq masking
    chk(irq === 1'b0, "R10 irq masked off", irq, 0);
    mask_wr = 1; mask_wdata = 5'h01;
    @(negedge clk);
    mask_wr = 0;
    chk(irq === 1'b1, "R10 irq masked on", irq, 1);
    clr_sts(5'h01);
    chk(irq === 1'b0 && status === 5'd0, "R10 irq after clear", irq, 0);

    // R6 illegal headers
    hdr(3'd2, 1'b0, 11'd511);
    cmd(4'd1, 3'd2);
    chk(busy === 1'b0 && status === 5'h10 && cs_out === 8'hFF, "R6 write count 511", status, 5'h10);
    clr_sts(5'h1F);
    hdr(3'd3, 1'b0, 11'd513);
    cmd(4'd1, 3'd2);
    chk(busy === 1'b0 && status === 5'h10, "R6 read count 513", status, 5'h10);
    clr_sts(5'h1F);
    hdr(3'd1, 1'b1, 11'd2);
    cmd(4'd1, 3'd2);
    chk(busy === 1'b0 && status === 5'h10, "R6 dual read-write", status, 5'h10);
    clr_sts(5'h1F);
    hdr(3'd6, 1'b0, 11'd2);
    cmd(4'd1, 3'd2);
    chk(busy === 1'b0 && status === 5'h10, "R6 op code 6", status, 5'h10);
    clr_sts(5'h1F);

    // R9 command codes
    hdr(3'd3, 1'b0, 11'd3);
    cmd(4'd2, 3'd2);
    chk(busy === 1'b0 && status === 5'h10, "R9 trigger code invalid", status, 5'h10);
    clr_sts(5'h1F);
    cmd(4'd0, 3'd2);
    chk(busy === 1'b0 && status === 5'd0, "R9 noop", {busy, status}, 0);
    bw(100, 8'h11);
    cmd(4'd1, 3'd2);
    strobe(2'b00); strobe(2'b00); strobe(2'b00); strobe(2'b00);
    cmd(4'd1, 3'd6);
    chk(busy === 1'b1 && cs_out === 8'hFB, "R9 start while busy ignored", cs_out, 8'hFB);
    bw(100, 8'hAA);
    cmd(4'd3, 3'd0);
    chk(busy === 1'b0 && status === 5'd0 && cs_out === 8'hFF, "R9 halt no done", {busy, status}, 0);
    rd(100, d);
    chk(d === 8'h11, "R1 write while busy ignored", d, 8'h11);
    bw(100, 8'h5C);
    rd(100, d);
    chk(d === 8'h5C, "R1 write while idle", d, 8'h5C);
    cmd(4'd1, 3'd0);
    cmd(4'd4, 3'd0);
    chk(busy === 1'b0 && status === 5'd0, "R9 flush no done", {busy, status}, 0);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule